// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and the write side of a parallel NOR flash port. The host hands it one operation at a time: an opcode, a target address, a data word and a word count, through a valid/ready request handshake. The block then plays out the fixed series of bus write cycles that the flash command state machine needs for that operation. Unlock writes and command writes use fixed word addresses and fixed command bytes, and the target cycles use the request's own address and data.

The write-cycle port carries one address/data pair with a strobe. The strobe stays high, with address and data held, until the bus side acknowledges that cycle, and only then does the next cycle start. For a buffered program, the words to store arrive on a separate valid/ready stream and are written to consecutive word addresses. A byte-mode input selects 8-bit memory wiring, in which every fixed command address is doubled before it reaches the bus. Completion polling, pin timing and reading back the flash are left to other logic.

Top module: `nor_cmd_seq`

## Requirements
- R1: Opcode 2 (program one word) emits four writes: 0xAA to command word 0x555, 0x55 to command word 0x2AA, 0xA0 to command word 0x555, then the request data to the unscaled request address.
- R2: Opcode 0 (identify) emits the same two unlock writes and then 0x90 to command word 0x555.
- R3: Opcode 1 (return to array read) emits exactly one write, 0xF0 to address 0. Opcode 6 (parameter query) emits exactly one write, 0x98 to command word 0x055.
- R4: Opcode 4 (sector erase) emits the two unlock writes, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and then 0x30 to the unscaled request address.
- R5: Opcode 5 (whole-device erase) emits the same first five writes as opcode 4 and then 0x10 to command word 0x555.
- R6: Opcode 3 (buffered program with N words) emits the two unlock writes, 0x25 to the request address, N-1 to the request address, N streamed words to request address + 0, +1, ... +N-1 in arrival order, and finally 0x29 to request address + N-1.
- R7: When byte_mode is 1 at the time a request is accepted, every fixed command word address is shifted left by one bit (0x555 becomes 0xAAA, 0x2AA becomes 0x554, 0x055 becomes 0x0AA). Request-derived addresses are never shifted.
- R8: req_ready is 1 only while the block is idle. A request offered while an operation is running is not taken and adds no bus writes.
- R9: At most one write is outstanding. Once bus_stb rises, bus_stb, bus_addr and bus_data hold until a cycle in which bus_ack is 1.
- R10: A request with opcode 3 and word count 0, or with opcode 7, raises err for one cycle and issues no bus write. busy stays 0.
- R11: After the acknowledge of the last write of an operation, done pulses for one cycle, busy returns to 0 and req_ready returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Target or start word address |
| req_data | input | DATA_W | Word for a single program |
| req_count | input | CNT_W | Word count for a buffered program |
| byte_mode | input | 1 | 1 selects 8-bit memory wiring |
| wd_valid | input | 1 | Buffered-program word available |
| wd_ready | output | 1 | Buffered-program word taken |
| wd_data | input | DATA_W | Buffered-program word |
| bus_addr | output | ADDR_W | Write-cycle address |
| bus_data | output | DATA_W | Write-cycle data |
| bus_stb | output | 1 | Write-cycle strobe |
| bus_ack | input | 1 | Write-cycle acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at operation end |
| err | output | 1 | One-cycle pulse on a rejected request |

## Verification
The assertions watch the cycle-level rules on every clock. They check that the strobe and its address and data hold until acknowledged, that a strobe only appears while busy, that req_ready is low while busy, that done follows an acknowledge and that a rejected request leaves the port quiet. They also check that a streamed word shows up on the bus in the cycle after its handshake. Only the directed scenarios can show that each opcode produces the right ordered list of address/data pairs. The same holds for byte-mode scaling, the count-minus-one and last-address confirm words of a buffered program under stream stalls, and for a request offered mid-operation leaving the sequence unchanged.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_IDENT     = 3'd0,
    OP_ARRAY_RD  = 3'd1,
    OP_PROG      = 3'd2,
    OP_BUFPROG   = 3'd3,
    OP_SECT_ERS  = 3'd4,
    OP_DEV_ERS   = 3'd5,
    OP_QUERY     = 3'd6,
    OP_INVALID   = 3'd7
  } op_e;

  // where a write cycle takes its address and data from
  typedef enum logic [2:0] {
    K_CMD,     // fixed command word address, fixed byte
    K_TCONST,  // request address, fixed byte
    K_TDATA,   // request address, request data
    K_COUNT,   // request address, count minus one
    K_STREAM,  // request address + index, streamed word
    K_LCONST   // last buffered address, fixed byte
  } kind_e;

  localparam int CMD_AW = 12;

  typedef struct packed {
    kind_e             kind;
    logic [CMD_AW-1:0] waddr;
    logic [7:0]        cbyte;
    logic              last;
  } step_t;

  function automatic step_t mk_step(kind_e k, logic [CMD_AW-1:0] a, logic [7:0] b, logic l);
    step_t s;
    s.kind  = k;
    s.waddr = a;
    s.cbyte = b;
    s.last  = l;
    return s;
  endfunction

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  output step_t             st
);

  always_comb begin
    st = mk_step(K_CMD, 12'h555, 8'hAA, 1'b0);
    case (op)
      OP_ARRAY_RD: st = mk_step(K_CMD, 12'h000, 8'hF0, 1'b1);
      OP_QUERY:    st = mk_step(K_CMD, 12'h055, 8'h98, 1'b1);
      default: begin
        if (step == STEP_W'(1)) begin
          st = mk_step(K_CMD, 12'h2AA, 8'h55, 1'b0);
        end else if (step != '0) begin
          case (op)
            OP_PROG: begin
              if (step == STEP_W'(2)) st = mk_step(K_CMD, 12'h555, 8'hA0, 1'b0);
              else                    st = mk_step(K_TDATA, 12'h000, 8'h00, 1'b1);
            end
            OP_IDENT: st = mk_step(K_CMD, 12'h555, 8'h90, 1'b1);
            OP_BUFPROG: begin
              case (step)
                STEP_W'(2): st = mk_step(K_TCONST, 12'h000, 8'h25, 1'b0);
                STEP_W'(3): st = mk_step(K_COUNT,  12'h000, 8'h00, 1'b0);
                STEP_W'(4): st = mk_step(K_STREAM, 12'h000, 8'h00, 1'b0);
                default:    st = mk_step(K_LCONST, 12'h000, 8'h29, 1'b1);
              endcase
            end
            default: begin
              // sector and whole-device erase share steps 2..4
              case (step)
                STEP_W'(2): st = mk_step(K_CMD, 12'h555, 8'h80, 1'b0);
                STEP_W'(3): st = mk_step(K_CMD, 12'h555, 8'hAA, 1'b0);
                STEP_W'(4): st = mk_step(K_CMD, 12'h2AA, 8'h55, 1'b0);
                default: begin
                  if (op == OP_DEV_ERS) st = mk_step(K_CMD, 12'h555, 8'h10, 1'b1);
                  else                  st = mk_step(K_TCONST, 12'h000, 8'h30, 1'b1);
                end
              endcase
            end
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/nor_seq_ascale.sv
module nor_seq_ascale
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [CMD_AW-1:0] waddr,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] baddr
);

  localparam int PAD = ADDR_W - CMD_AW - 1;

  generate
    if (PAD > 0) begin : g_pad
      assign baddr = byte_mode ? {{PAD{1'b0}}, waddr, 1'b0}
                               : {{(PAD+1){1'b0}}, waddr};
    end else begin : g_nopad
      assign baddr = byte_mode ? {waddr, 1'b0} : {1'b0, waddr};
    end
  endgenerate

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              byte_mode,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_stb,
  input  logic              bus_ack,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int STEP_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e            state;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  widx;
  logic [STEP_W-1:0] step_q;
  logic              bm_q;

  step_t             st;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_data;
  logic              iss_go;
  logic [CNT_W-1:0]  cnt_m1;
  logic              accept;
  logic              bad_req;

  nor_seq_script #(.STEP_W(STEP_W)) u_script (
    .op   (op_q),
    .step (step_q),
    .st   (st)
  );

  nor_seq_ascale #(.ADDR_W(ADDR_W)) u_ascale (
    .waddr     (st.waddr),
    .byte_mode (bm_q),
    .baddr     (cmd_addr)
  );

  assign cnt_m1  = cnt_q - 1'b1;
  assign accept  = req_valid && req_ready;
  assign bad_req = (req_op == OP_INVALID) ||
                   ((req_op == OP_BUFPROG) && (req_count == '0));
  assign wd_ready = (state == S_ISSUE) && (st.kind == K_STREAM);

  // source selection for the next write cycle
  always_comb begin
    iss_go   = 1'b1;
    iss_addr = addr_q;
    iss_data = {{(DATA_W-8){1'b0}}, st.cbyte};
    case (st.kind)
      K_CMD:    iss_addr = cmd_addr;
      K_TDATA:  iss_data = data_q;
      K_COUNT:  iss_data = {{(DATA_W-CNT_W){1'b0}}, cnt_m1};
      K_STREAM: begin
        iss_addr = addr_q + {{(ADDR_W-CNT_W){1'b0}}, widx};
        iss_data = wd_data;
        iss_go   = wd_valid;
      end
      K_LCONST: iss_addr = last_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_IDENT;
      addr_q    <= '0;
      last_q    <= '0;
      data_q    <= '0;
      cnt_q     <= '0;
      widx      <= '0;
      step_q    <= '0;
      bm_q      <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
      bus_stb   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (bad_req) begin
              err <= 1'b1;
            end else begin
              op_q      <= op_e'(req_op);
              addr_q    <= req_addr;
              last_q    <= req_addr + {{(ADDR_W-CNT_W){1'b0}}, req_count} - 1'b1;
              data_q    <= req_data;
              cnt_q     <= req_count;
              bm_q      <= byte_mode;
              widx      <= '0;
              step_q    <= '0;
              busy      <= 1'b1;
              req_ready <= 1'b0;
              state     <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (iss_go) begin
            bus_addr <= iss_addr;
            bus_data <= iss_data;
            bus_stb  <= 1'b1;
            state    <= S_WAIT;
          end
        end
        default: begin
          if (bus_ack) begin
            bus_stb <= 1'b0;
            if (st.last) begin
              done      <= 1'b1;
              busy      <= 1'b0;
              req_ready <= 1'b1;
              state     <= S_IDLE;
            end else begin
              if ((st.kind == K_STREAM) && (widx != cnt_m1)) begin
                widx <= widx + 1'b1;
              end else begin
                step_q <= step_q + 1'b1;
              end
              state <= S_ISSUE;
            end
          end
        end
      endcase
    end
  end

  // R9
  stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb && !bus_ack |=> bus_stb && $stable(bus_addr) && $stable(bus_data));

  // R9
  stb_in_op_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> busy);

  // R8
  refuse_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  // R11
  done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_ack) && !busy && req_ready);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy && !bus_stb);

  // R6
  stream_launch_chk: assert property (@(posedge clk) disable iff (rst)
    wd_valid && wd_ready |=> bus_stb && (bus_data == $past(wd_data)));

endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              byte_mode = 1'b0;
  logic              wd_valid = 1'b0;
  logic              wd_ready;
  logic [DATA_W-1:0] wd_data = '0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic              bus_stb;
  logic              bus_ack = 1'b0;
  logic              busy, done, err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_count(req_count), .byte_mode(byte_mode), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_data(wd_data), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_stb(bus_stb), .bus_ack(bus_ack),
    .busy(busy), .done(done), .err(err)
  );

  // bus responder and write log
  int lat = 0;
  int wcnt = 0;
  int nlog = 0;
  logic [ADDR_W-1:0] log_a [64];
  logic [DATA_W-1:0] log_d [64];
  logic [ADDR_W-1:0] held_a;
  logic [DATA_W-1:0] held_d;
  logic              holding = 1'b0;

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack <= 1'b0;
      holding <= 1'b0;
    end else if (bus_stb) begin
      if (holding && (bus_addr !== held_a || bus_data !== held_d)) begin
        tests++; fails++;
        $display("FAIL R9 write changed before ack: act %h/%h exp %h/%h",
                 bus_addr, bus_data, held_a, held_d);
      end
      held_a  <= bus_addr;
      held_d  <= bus_data;
      holding <= 1'b1;
      if (wcnt >= lat) begin
        bus_ack <= 1'b1;
        wcnt    <= 0;
        if (nlog < 64) begin
          log_a[nlog] <= bus_addr;
          log_d[nlog] <= bus_data;
        end
        nlog <= nlog + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // stream source with periodic gaps
  logic [DATA_W-1:0] sbuf [64];
  int sn = 0;
  int si = 0;
  int sgap = 0;
  logic spend = 1'b0;

  always @(negedge clk) begin
    automatic int idx = si;
    if (spend) idx = si + 1;
    si    = idx;
    spend = 1'b0;
    sgap  = sgap + 1;
    wd_valid = (idx < sn) && (sgap % 3 != 0);
    wd_data  = (idx < 64) ? sbuf[idx] : '0;
    if (wd_valid && wd_ready) spend = 1'b1;
  end

  // expected list
  int nexp = 0;
  logic [ADDR_W-1:0] exp_a [64];
  logic [DATA_W-1:0] exp_d [64];

  task automatic push(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    exp_a[nexp] = a;
    exp_d[nexp] = d;
    nexp++;
  endtask

  function automatic logic [ADDR_W-1:0] ca(input logic [11:0] w, input logic bm);
    return bm ? ADDR_W'({w, 1'b0}) : ADDR_W'(w);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic unlock(input logic bm);
    push(ca(12'h555, bm), 16'h00AA);
    push(ca(12'h2AA, bm), 16'h0055);
  endtask

  // issue one request and compare the write log with the expected list
  task automatic run_op(input string tag, input logic [2:0] op, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] c, input logic bm);
    int t;
    @(negedge clk);
    nlog = 0;
    si = 0; spend = 1'b0;
    check(req_ready === 1'b1, {tag, " ready before request"}, 32'(req_ready), 1);
    req_op = op; req_addr = a; req_data = d; req_count = c; byte_mode = bm;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done === 1'b1, {tag, " done pulse (R11)"}, 32'(done), 1);
    check(busy === 1'b0 && req_ready === 1'b1, {tag, " idle at done (R11)"},
          32'({busy, req_ready}), 32'b01);
    @(negedge clk);
    check(done === 1'b0, {tag, " done one cycle (R11)"}, 32'(done), 0);
    check(nlog == nexp, {tag, " write count (R9)"}, 32'(nlog), 32'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++) begin
      check(log_a[i] === exp_a[i] && log_d[i] === exp_d[i], tag,
            {log_a[i][15:0], log_d[i]}, {exp_a[i][15:0], exp_d[i]});
    end
    nexp = 0;
  endtask

  task automatic t_reset_state();
    check(busy === 0 && done === 0 && err === 0 && bus_stb === 0,
          "R11 reset outputs quiet", 32'({busy, done, err, bus_stb}), 0);
    check(req_ready === 1'b1, "R8 ready after reset", 32'(req_ready), 1);
  endtask

  task automatic t_program();
    lat = 0;
    unlock(0); push(ca(12'h555, 0), 16'h00A0); push(24'h001234, 16'hBEEF);
    run_op("R1 program", 3'd2, 24'h001234, 16'hBEEF, '0, 1'b0);
  endtask

  task automatic t_ident();
    lat = 1;
    unlock(0); push(ca(12'h555, 0), 16'h0090);
    run_op("R2 identify", 3'd0, 24'h000000, 16'h0, '0, 1'b0);
  endtask

  task automatic t_single_writes();
    lat = 2;
    push(24'h000000, 16'h00F0);
    run_op("R3 array read", 3'd1, 24'h00ABCD, 16'h0, '0, 1'b0);
    push(ca(12'h055, 0), 16'h0098);
    run_op("R3 query", 3'd6, 24'h000000, 16'h0, '0, 1'b0);
  endtask

  task automatic t_sector_erase();
    lat = 0;
    unlock(0); push(ca(12'h555, 0), 16'h0080); push(ca(12'h555, 0), 16'h00AA);
    push(ca(12'h2AA, 0), 16'h0055); push(24'h010000, 16'h0030);
    run_op("R4 sector erase", 3'd4, 24'h010000, 16'h0, '0, 1'b0);
  endtask

  task automatic t_device_erase();
    lat = 3;
    unlock(0); push(ca(12'h555, 0), 16'h0080); push(ca(12'h555, 0), 16'h00AA);
    push(ca(12'h2AA, 0), 16'h0055); push(ca(12'h555, 0), 16'h0010);
    run_op("R5 device erase", 3'd5, 24'h0F0000, 16'h0, '0, 1'b0);
  endtask

  task automatic t_bufprog(input int n, input logic [ADDR_W-1:0] a);
    lat = 1;
    sn = n;
    for (int i = 0; i < n; i++) sbuf[i] = 16'hC000 + 16'(i * 7);
    unlock(0); push(a, 16'h0025); push(a, 16'(n - 1));
    for (int i = 0; i < n; i++) push(a + ADDR_W'(i), 16'hC000 + 16'(i * 7));
    push(a + ADDR_W'(n - 1), 16'h0029);
    run_op("R6 buffered program", 3'd3, a, 16'h0, CNT_W'(n), 1'b0);
    sn = 0;
  endtask

  task automatic t_byte_mode();
    lat = 0;
    unlock(1); push(ca(12'h555, 1), 16'h00A0); push(24'h000777, 16'h1357);
    run_op("R7 byte-mode program", 3'd2, 24'h000777, 16'h1357, '0, 1'b1);
    push(24'h0000AA, 16'h0098);
    run_op("R7 byte-mode query", 3'd6, 24'h0, 16'h0, '0, 1'b1);
    unlock(1); push(ca(12'h555, 1), 16'h0080); push(ca(12'h555, 1), 16'h00AA);
    push(24'h000554, 16'h0055); push(24'h003000, 16'h0030);
    run_op("R7 byte-mode erase", 3'd4, 24'h003000, 16'h0, '0, 1'b1);
  endtask

  task automatic t_busy_refuse();
    int t;
    lat = 6;
    unlock(0); push(ca(12'h555, 0), 16'h0080); push(ca(12'h555, 0), 16'h00AA);
    push(ca(12'h2AA, 0), 16'h0055); push(ca(12'h555, 0), 16'h0010);
    @(negedge clk);
    nlog = 0;
    req_op = 3'd5; req_addr = '0; req_count = '0; byte_mode = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1 && req_ready === 1'b0, "R8 busy refuses", 32'({busy, req_ready}), 32'b10);
    req_op = 3'd1; req_valid = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done === 1'b1, "R8 original op completes", 32'(done), 1);
    repeat (4) @(negedge clk);
    check(nlog == nexp, "R8 no extra writes from refused request", 32'(nlog), 32'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++)
      check(log_a[i] === exp_a[i] && log_d[i] === exp_d[i], "R8 sequence unchanged",
            {log_a[i][15:0], log_d[i]}, {exp_a[i][15:0], exp_d[i]});
    nexp = 0;
  endtask

  task automatic t_reject(input logic [2:0] op, input logic [CNT_W-1:0] c, input string tag);
    bit seen;
    @(negedge clk);
    nlog = 0;
    req_op = op; req_count = c; req_addr = 24'h000100; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = (err === 1'b1);
    check(seen, {tag, " err pulse"}, 32'(err), 1);
    check(busy === 1'b0, {tag, " stays idle"}, 32'(busy), 0);
    repeat (5) @(negedge clk);
    check(err === 1'b0, {tag, " err cleared"}, 32'(err), 0);
    check(nlog == 0 && bus_stb === 1'b0, {tag, " no writes"}, 32'(nlog), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_program();
    t_ident();
    t_single_writes();
    t_sector_erase();
    t_device_erase();
    t_bufprog(4, 24'h000200);
    t_bufprog(1, 24'h0004F0);
    t_bufprog(9, 24'h001000);
    t_byte_mode();
    t_busy_refuse();
    t_reject(3'd3, '0, "R10 zero count");
    t_reject(3'd7, 6'd3, "R10 bad opcode");
    t_program();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule